// File: doc/BRIEF.md
# Programmable Reference Frequency Divider

This block turns a reference clock into the comparison pulse that a phase comparator needs. A fixed divide-by-4 prescaler feeds a 16-bit programmable counter. The output is one pulse every 4 × B reference clocks, where B is the counter setting.

B is loaded through a three-wire serial port: data, shift clock and latch. The port carries a 24-bit word. Besides B, the same word holds a bit that decides whether an external unlock flag reaches the lock-detect pin or whether that pin is held low. The last two bits of the word address a register. Only a word whose address matches this block's code is taken. All serial lines are sampled in the reference-clock domain.

A new B never cuts an interval short. The interval in progress finishes with the old setting, and the new setting starts at the next terminal count. After reset the divider runs at the minimum setting, B = 5 (R = 20), and the lock-detect pin is held low.

Top module: `refdiv_top`

## Requirements
- R1: For a loaded B between 5 and 65535, `cmp_pulse` rises once every 4 × B cycles of `clk_ref`.
- R2: Each pulse on `cmp_pulse` is exactly one `clk_ref` cycle wide.
- R3: A loaded B below 5 (including 0) is treated as 5, which gives an interval of 20 cycles.
- R4: The word is shifted MSB first on rising edges of `ser_clk`. Word bits 1 to 16 (the first 16 shifted) hold B, with bit 1 weighing 2^15 and bit 16 weighing 2^0.
- R5: Word bit 20 is the lock-detect enable. With it at 1, `lock_pin` follows `unlock_in`. With it at 0, `lock_pin` is 0.
- R6: Word bits 17, 18, 19, 21 and 22 have no effect on the interval or on `lock_pin`, whatever their values.
- R7: Word bits 23 and 24 (the last two shifted, bit 23 the more significant) form an address. A rising edge on `ser_latch` takes the word only when this address equals the parameter `REG_SEL` (default 2'b00). Otherwise the interval and the lock-detect enable stay unchanged.
- R8: A new B takes effect only at a terminal count. The interval in progress when the word is latched keeps its old length, every interval has either the old or the new length, and the switch to the new length happens once.
- R9: While reset is asserted, `cmp_pulse` and `lock_pin` are 0. After reset the divider runs with B = 5 (an interval of 20 cycles) and the lock-detect enable is 0.
- R10: A setting of B = 144 gives an interval of 576 reference clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data | input | 1 | Serial word data, MSB first |
| ser_clk | input | 1 | Serial shift clock; its rising edge shifts one bit |
| ser_latch | input | 1 | Rising edge transfers the shifted word |
| unlock_in | input | 1 | Unlock flag from the phase comparator |
| cmp_pulse | output | 1 | Comparison pulse, one clock wide |
| lock_pin | output | 1 | Gated lock-detect output |

## Verification
A latch strobe and a terminal count can land in the same reference-clock cycle. When that happens, the counter reloads from the shadow value that was there before the strobe wrote it.

To provoke this, the bench first shifts a new value in without latching it. It then lines up on a comparison pulse and raises the latch after an offset. The offset is swept across every clock slot of a full interval, so the strobe also reaches the terminal slot itself.

For each offset, the four following intervals must each be exactly the old or the new length. They must switch from old to new only once, and the last one must be new. The sweep must also show that both outcomes happen for the second interval.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  // layout of the serial control word (bit 1 arrives first)
  localparam int WORD_W = 24;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 2;
  localparam int LD_POS = WORD_W - 20;  // word bit 20 after full shift
  localparam int B_MIN  = 5;

  typedef logic [CNT_W-1:0]  div_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/refdiv_sync.sv
module refdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_nxt;

    always_comb begin
      chain_nxt = {chain_q[STAGES-2:0], d[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_nxt;
    end

    assign q[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/refdiv_shift.sv
module refdiv_shift
  import refdiv_pkg::*;
#(
  parameter logic [SEL_W-1:0] REG_SEL = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic latch_s,
  input  logic sdata_s,
  output logic load_ok,
  output div_t b_val,
  output logic ld_bit
);
  logic  sclk_q, latch_q;
  logic  shift_en, strobe;
  word_t sr_q, sr_nxt;
  div_t  b_raw;

  assign shift_en = sclk_s & ~sclk_q;
  assign strobe   = latch_s & ~latch_q;

  always_comb begin
    sr_nxt = sr_q;
    if (shift_en) sr_nxt = {sr_q[WORD_W-2:0], sdata_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      sr_q    <= '0;
    end else begin
      sclk_q  <= sclk_s;
      latch_q <= latch_s;
      sr_q    <= sr_nxt;
    end
  end

  // decode: count field in front, address field at the tail
  assign b_raw   = sr_q[WORD_W-1 -: CNT_W];
  assign b_val   = (b_raw < div_t'(B_MIN)) ? div_t'(B_MIN) : b_raw;
  assign ld_bit  = sr_q[LD_POS];
  assign load_ok = strobe && (sr_q[SEL_W-1:0] == REG_SEL);

  assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PRE_W-1:0] pre_q, pre_nxt;

  assign tick = (pre_q == PRE_W'(PRE_DIV - 1));

  always_comb begin
    pre_nxt = tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end

  assert_pre_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));
  assert_pre_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (pre_q == $past(pre_q) + 1'b1));
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  div_t load_val,
  output logic pulse
);
  div_t shadow_q, shadow_nxt;
  div_t cur_q, cur_nxt;
  div_t cnt_q, cnt_nxt;
  logic pulse_q;
  logic term;

  assign term = tick && (cnt_q == cur_q - 1'b1);

  always_comb begin
    shadow_nxt = shadow_q;
    cur_nxt    = cur_q;
    cnt_nxt    = cnt_q;
    if (load) shadow_nxt = load_val;
    if (term) begin
      cnt_nxt = '0;
      cur_nxt = shadow_q;  // pre-strobe value when both coincide
    end else if (tick) begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= div_t'(B_MIN);
      cur_q    <= div_t'(B_MIN);
      cnt_q    <= '0;
      pulse_q  <= 1'b0;
    end else begin
      shadow_q <= shadow_nxt;
      cur_q    <= cur_nxt;
      cnt_q    <= cnt_nxt;
      pulse_q  <= term;
    end
  end

  assign pulse = pulse_q;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_q);
  assert_cur_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q >= div_t'(B_MIN));
  assert_cur_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> $stable(cur_q));
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int                PRE_DIV     = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [SEL_W-1:0]  REG_SEL     = '0
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic ser_data,
  input  logic ser_clk,
  input  logic ser_latch,
  input  logic unlock_in,
  output logic cmp_pulse,
  output logic lock_pin
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [2:0] ser_raw, ser_s;
  logic       load_ok, ld_bit, tick;
  div_t       b_val;
  logic       ld_en_q, ld_en_nxt;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign ser_raw = {ser_data, ser_latch, ser_clk};

  refdiv_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(rst_int_n), .d(ser_raw), .q(ser_s));

  refdiv_shift #(.REG_SEL(REG_SEL)) u_shift (
    .clk(clk_ref), .rst_n(rst_int_n),
    .sclk_s(ser_s[0]), .latch_s(ser_s[1]), .sdata_s(ser_s[2]),
    .load_ok(load_ok), .b_val(b_val), .ld_bit(ld_bit));

  refdiv_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk_ref), .rst_n(rst_int_n), .tick(tick));

  refdiv_count u_cnt (
    .clk(clk_ref), .rst_n(rst_int_n), .tick(tick),
    .load(load_ok), .load_val(b_val), .pulse(cmp_pulse));

  always_comb begin
    ld_en_nxt = ld_en_q;
    if (load_ok) ld_en_nxt = ld_bit;
  end

  always_ff @(posedge clk_ref or negedge rst_int_n) begin
    if (!rst_int_n) ld_en_q <= 1'b0;
    else            ld_en_q <= ld_en_nxt;
  end

  assign lock_pin = ld_en_q & unlock_in;

  assert_pulse_width_R2: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    cmp_pulse |=> !cmp_pulse);
  assert_ld_hold_R7: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    !load_ok |=> $stable(ld_en_q));
endmodule

// File: tb/refdiv_top_test.sv
`timescale 1ns/1ps
module refdiv_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0, unlock_in = 1'b0;
  logic cmp_pulse, lock_pin;

  int checks = 0, errors = 0;
  int cyc = 0;
  int npulse = 0;
  int pt [256];
  int wide = 0;
  logic prev_p = 1'b0;
  bit done = 1'b0;

  refdiv_top uut (
    .clk_ref(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .unlock_in(unlock_in),
    .cmp_pulse(cmp_pulse), .lock_pin(lock_pin));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmp_pulse) begin
      pt[npulse & 255] = cyc;
      npulse = npulse + 1;
      if (prev_p) wide = wide + 1;
    end
    prev_p = cmp_pulse;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [15:0] b, input logic ld,
                                     input logic [2:0] u, input logic [1:0] t,
                                     input logic [1:0] s);
    return {b, u, ld, t, s};
  endfunction

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_data = w[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic strobe();
    ser_latch = 1'b1;
    repeat (4) @(negedge clk);
    ser_latch = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_n(input int k);
    int tgt = npulse + k;
    while (npulse < tgt) @(negedge clk);
  endtask

  task automatic period(output int d);
    wait_n(2);
    d = pt[(npulse - 1) & 255] - pt[(npulse - 2) & 255];
  endtask

  task automatic program_word(input logic [23:0] w);
    shift_word(w);
    strobe();
    wait_n(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    int sw_old, sw_new;
    // R9: reset state
    unlock_in = 1'b1;
    repeat (6) @(negedge clk);
    check(cmp_pulse == 1'b0, "R9 pulse in reset", cmp_pulse, 0);
    check(lock_pin == 1'b0, "R9 lock pin in reset", lock_pin, 0);
    rst_n = 1'b1;
    period(d);
    check(d == 20, "R9 interval after reset", d, 20);
    check(lock_pin == 1'b0, "R9 lock enable off after reset", lock_pin, 0);

    // R1 / R4: sweep of small settings
    for (int b = 5; b <= 13; b++) begin
      program_word(mk(16'(b), 1'b0, 3'b000, 2'b00, 2'b00));
      period(d);
      check(d == 4 * b, $sformatf("R1 R4 interval B=%0d", b), d, 4 * b);
    end

    // R3: clamp
    foreach (sw_new_vals[k]) begin end
    for (int b = 0; b <= 4; b++) begin
      program_word(mk(16'(b), 1'b0, 3'b000, 2'b00, 2'b00));
      period(d);
      check(d == 20, $sformatf("R3 clamp B=%0d", b), d, 20);
    end

    // R10: worked example
    program_word(mk(16'd144, 1'b0, 3'b000, 2'b00, 2'b00));
    period(d);
    check(d == 576, "R10 B=144", d, 576);

    // R5: lock-detect gating
    program_word(mk(16'd7, 1'b1, 3'b000, 2'b00, 2'b00));
    unlock_in = 1'b1; @(negedge clk);
    check(lock_pin == 1'b1, "R5 enabled high", lock_pin, 1);
    unlock_in = 1'b0; @(negedge clk);
    check(lock_pin == 1'b0, "R5 enabled low", lock_pin, 0);
    program_word(mk(16'd7, 1'b0, 3'b000, 2'b00, 2'b00));
    unlock_in = 1'b1; @(negedge clk);
    check(lock_pin == 1'b0, "R5 disabled held low", lock_pin, 0);

    // R6: don't-care bits set
    program_word(mk(16'd8, 1'b1, 3'b111, 2'b11, 2'b00));
    period(d);
    check(d == 32, "R6 interval with junk bits", d, 32);
    check(lock_pin == 1'b1, "R6 lock pin with junk bits", lock_pin, 1);
    program_word(mk(16'd8, 1'b0, 3'b101, 2'b10, 2'b00));
    check(lock_pin == 1'b0, "R6 enable clear with junk bits", lock_pin, 0);

    // R7: foreign addresses ignored
    program_word(mk(16'd7, 1'b1, 3'b000, 2'b00, 2'b00));
    for (int s = 1; s <= 3; s++) begin
      program_word(mk(16'd11, 1'b0, 3'b000, 2'b00, 2'(s)));
      check(lock_pin == 1'b1, $sformatf("R7 lock kept sel=%0d", s), lock_pin, 1);
      period(d);
      check(d == 28, $sformatf("R7 interval kept sel=%0d", s), d, 28);
    end

    // R8: latch strobe swept across an interval, including terminal slot
    sw_old = 0; sw_new = 0;
    for (int off = 0; off <= 27; off++) begin
      int n0;
      int iv [4];
      bit seen_new, ok;
      program_word(mk(16'd6, 1'b0, 3'b000, 2'b00, 2'b00));
      shift_word(mk(16'd9, 1'b0, 3'b000, 2'b00, 2'b00));
      wait_n(1);
      n0 = npulse;
      repeat (off) @(negedge clk);
      strobe();
      while (npulse < n0 + 4) @(negedge clk);
      ok = 1'b1; seen_new = 1'b0;
      for (int k = 0; k < 4; k++) begin
        iv[k] = pt[(n0 + k) & 255] - pt[(n0 + k - 1) & 255];
        if (iv[k] == 36) seen_new = 1'b1;
        else if (iv[k] != 24 || seen_new) ok = 1'b0;
      end
      check(ok && iv[0] == 24 && iv[3] == 36,
            $sformatf("R8 switch off=%0d i1/i4", off), iv[0] * 100 + iv[3], 2436);
      if (iv[1] == 24) sw_old++; else sw_new++;
    end
    check(sw_old > 0, "R8 second interval kept old", sw_old, 1);
    check(sw_new > 0, "R8 second interval took new", sw_new, 1);

    // R2: width of every pulse seen
    check(wide == 0, "R2 pulse width one cycle", wide, 0);
    check(npulse > 100, "R2 pulses observed", npulse, 100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int sw_new_vals [1];
endmodule